// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits beside a processor that announces each bus transfer through a three-bit status code, and turns that code into individual bus control strobes: separate memory read, memory write, I/O read, I/O write and interrupt acknowledge commands, an address latch pulse, an active-high data buffer enable and a data direction line. A transfer is recognised only from the status lines. A move away from the passive code starts a cycle, and a return to passive while ready is high ends it.

Internally a five-state tracker (idle, T1, T2, T3/wait, T4) follows the processor's clock states. A flop on the falling clock edge gives the half-cycle placement that the data enable needs. Halt and passive codes produce neither a command nor an address latch pulse. A reset input forces every output to its inactive level at once.

Top module: `bus_cmd_decoder`

## Requirements
- R1: The status code selects the command: 000 interrupt acknowledge (inta_n), 001 I/O read (iord_n), 010 I/O write (iowr_n), 100 code fetch and 101 memory read (both mrd_n), 110 memory write (mwr_n). Command outputs are active low, and at most one is low at any time.
- R2: A cycle starts when the status, sampled at a rising edge, differs from the passive code 111 after being 111 at the previous rising edge, while the tracker is idle or in T4. The halt code 011 never starts a cycle, and produces no strobe and no ale pulse.
- R3: In T3 the tracker moves to T4 only when a rising edge samples status 111 together with rdy high. Otherwise it stays in T3 as a wait state.
- R4: ale is high for exactly the one clock of T1 of each started cycle and low at all other times.
- R5: The selected command is low throughout T2, T3 and every wait state, and high in idle, T1 and T4.
- R6: dt_r is high from T1 through T4 of a write cycle (codes 010 and 110) and low at all other times.
- R7: For read, fetch and interrupt acknowledge cycles, den rises at the falling edge inside T2 and falls at the falling edge inside T4.
- R8: For write cycles, den rises at the start of T2 and falls at the falling edge inside T4.
- R9: While rst is high, all commands are high and ale, den and dt_r are low, starting in the same cycle that rst rises.
- R10: A new non-passive code presented during T4, after passive was sampled at T4's opening edge, makes the next clock T1 of the new cycle with no idle clock between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; both edges used |
| rst | input | 1 | Active-high reset, asynchronous |
| stat | input | 3 | Encoded processor bus status |
| rdy | input | 1 | Ready from the addressed device; low stretches T3 |
| ale | output | 1 | Address latch pulse during T1 |
| den | output | 1 | Data buffer enable, active high |
| dt_r | output | 1 | Buffer direction: 1 transmit, 0 receive |
| mrd_n | output | 1 | Memory read command, active low |
| mwr_n | output | 1 | Memory write command, active low |
| iord_n | output | 1 | I/O read command, active low |
| iowr_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |

## Verification
The end of one cycle and the start of the next can fall in the same T4: the falling data enable of the old cycle and the detection that leads to the new cycle's T1. The bench provokes this by driving a new code right after the opening edge of T4, then chaining a read onto a write and a write onto a read. It checks that den still falls at mid-T4 for the old cycle and that ale rises in the very next clock. It also checks that the new cycle's direction and command appear without leaking from the old one.

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] stat,
  input  logic       rdy,
  output logic       ale,
  output logic       den,
  output logic       dt_r,
  output logic       mrd_n,
  output logic       mwr_n,
  output logic       iord_n,
  output logic       iowr_n,
  output logic       inta_n
);
  localparam logic [2:0] C_INTA  = 3'b000;
  localparam logic [2:0] C_IORD  = 3'b001;
  localparam logic [2:0] C_IOWR  = 3'b010;
  localparam logic [2:0] C_HALT  = 3'b011;
  localparam logic [2:0] C_FETCH = 3'b100;
  localparam logic [2:0] C_MRD   = 3'b101;
  localparam logic [2:0] C_MWR   = 3'b110;
  localparam logic [2:0] C_IDLE  = 3'b111;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_T4} tstate_t;

  tstate_t    tst, tst_nx;
  logic [2:0] code_q;
  logic       was_passive;
  logic       den_half;
  logic       start, cmd_win, is_wr;

  assign start   = was_passive && stat != C_IDLE && stat != C_HALT &&
                   (tst == S_IDLE || tst == S_T4);
  assign is_wr   = code_q == C_IOWR || code_q == C_MWR;
  assign cmd_win = !rst && (tst == S_T2 || tst == S_T3);

  always_comb begin
    tst_nx = tst;
    case (tst)
      S_IDLE:  if (start) tst_nx = S_T1;
      S_T1:    tst_nx = S_T2;
      S_T2:    tst_nx = S_T3;
      S_T3:    if (stat == C_IDLE && rdy) tst_nx = S_T4;
      S_T4:    tst_nx = start ? S_T1 : S_IDLE;
      default: tst_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      tst         <= S_IDLE;
      code_q      <= C_IDLE;
      was_passive <= 1'b0;
    end else begin
      tst         <= tst_nx;
      was_passive <= stat == C_IDLE;
      if (start) code_q <= stat;
    end
  end

  always_ff @(negedge clk or posedge rst) begin
    if (rst) den_half <= 1'b0;
    else     den_half <= tst == S_T2 || tst == S_T3;
  end

  assign ale    = !rst && tst == S_T1;
  assign den    = !rst && (den_half || (is_wr && cmd_win));
  assign dt_r   = !rst && tst != S_IDLE && is_wr;
  assign mrd_n  = !(cmd_win && (code_q == C_MRD || code_q == C_FETCH));
  assign mwr_n  = !(cmd_win && code_q == C_MWR);
  assign iord_n = !(cmd_win && code_q == C_IORD);
  assign iowr_n = !(cmd_win && code_q == C_IOWR);
  assign inta_n = !(cmd_win && code_q == C_INTA);

  p_one_cmd_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~mrd_n, ~mwr_n, ~iord_n, ~iowr_n, ~inta_n}));

  p_halt_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (tst == S_IDLE && stat == C_HALT) |=> !ale);

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (tst == S_T3 && !rdy) |=> tst == S_T3);

  p_ale_single_r4: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  p_cmd_after_ale_r5: assert property (@(posedge clk) disable iff (rst)
    ale |=> !($countones({mrd_n, mwr_n, iord_n, iowr_n, inta_n}) == 5));

  p_dir_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (tst == S_T2) |=> $stable(dt_r));

  p_den_in_t3_r7: assert property (@(posedge clk) disable iff (rst)
    (tst == S_T3) |-> den);
endmodule

// File: tb/bus_cmd_decoder_test.sv
module bus_cmd_decoder_test;
  logic clk = 1'b0, rst = 1'b1, rdy = 1'b1;
  logic [2:0] stat = 3'b111;
  logic ale, den, dt_r, mrd_n, mwr_n, iord_n, iowr_n, inta_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_cmd_decoder uut (.clk(clk), .rst(rst), .stat(stat), .rdy(rdy), .ale(ale), .den(den),
    .dt_r(dt_r), .mrd_n(mrd_n), .mwr_n(mwr_n), .iord_n(iord_n), .iowr_n(iowr_n), .inta_n(inta_n));

  // phase: 0 idle, 1 T1, 2 T2 early, 3 T2 late, 4 T3/Tw, 5 T4 early, 6 T4 late
  function automatic logic [7:0] expect_out(input logic [2:0] code, input int ph);
    logic wr, act;
    logic [4:0] cmd;
    wr  = code == 3'b010 || code == 3'b110;
    act = ph >= 2 && ph <= 4;
    cmd = 5'b11111;
    if (act) case (code)
      3'b000: cmd[0] = 1'b0;
      3'b001: cmd[2] = 1'b0;
      3'b010: cmd[1] = 1'b0;
      3'b100, 3'b101: cmd[4] = 1'b0;
      3'b110: cmd[3] = 1'b0;
      default: ;
    endcase
    // {ale, den, dt_r, mrd_n, mwr_n, iord_n, iowr_n, inta_n}
    return {ph == 1, wr ? (ph >= 2 && ph <= 5) : (ph >= 3 && ph <= 5),
            wr && ph >= 1, cmd};
  endfunction

  task automatic chk(input string req, input logic [7:0] exp);
    logic [7:0] act;
    act = {ale, den, dt_r, mrd_n, mwr_n, iord_n, iowr_n, inta_n};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step; @(posedge clk); #1; endtask

  // Runs one cycle; if chained, code was already driven during the previous T4.
  task automatic run_cycle(input logic [2:0] code, input int waits, input bit chained,
                           input bit chain_out, input logic [2:0] next_code);
    if (!chained) stat = code;
    step; chk("R2 R4 R6 T1", expect_out(code, 1));
    step; chk("R5 R8 T2 early", expect_out(code, 2));
    #2;   chk("R7 T2 late", expect_out(code, 3));
    step; chk("R5 T3", expect_out(code, 4));
    stat = 3'b111;
    rdy  = waits == 0;
    for (int w = 0; w < waits; w++) begin
      step; chk("R3 wait state", expect_out(code, 4));
      if (w == waits - 1) rdy = 1'b1;
    end
    step; chk("R3 R5 T4 early", expect_out(code, 5));
    if (chain_out) stat = next_code;
    #2;   chk("R7 R8 T4 late", expect_out(code, 6));
  endtask

  task automatic t_reset;
    #1; chk("R9 in reset", 8'b0001_1111);
    step; step; rst = 1'b0;
    step; chk("R9 after reset", 8'b0001_1111);
  endtask

  task automatic t_all_codes;
    logic [2:0] codes [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
    foreach (codes[i]) begin
      run_cycle(codes[i], 0, 1'b0, 1'b0, 3'b111);
      step; chk("R1 R4 back to idle", expect_out(3'b111, 0));
    end
  endtask

  task automatic t_waits;
    run_cycle(3'b101, 3, 1'b0, 1'b0, 3'b111);
    step; chk("R3 idle after read with waits", expect_out(3'b111, 0));
    run_cycle(3'b010, 2, 1'b0, 1'b0, 3'b111);
    step; chk("R3 idle after write with waits", expect_out(3'b111, 0));
  endtask

  task automatic t_halt;
    stat = 3'b011;
    for (int i = 0; i < 4; i++) begin
      step; chk("R2 halt gives nothing", expect_out(3'b111, 0));
    end
    stat = 3'b111;
    step; chk("R2 passive after halt", expect_out(3'b111, 0));
    run_cycle(3'b001, 0, 1'b0, 1'b0, 3'b111);
    step; chk("R2 idle after halt then read", expect_out(3'b111, 0));
  endtask

  task automatic t_chain;
    run_cycle(3'b110, 0, 1'b0, 1'b1, 3'b101);
    run_cycle(3'b101, 1, 1'b1, 1'b1, 3'b010);
    run_cycle(3'b010, 0, 1'b1, 1'b1, 3'b000);
    run_cycle(3'b000, 0, 1'b1, 1'b0, 3'b111);
    step; chk("R10 idle after chain", expect_out(3'b111, 0));
  endtask

  task automatic t_reset_mid;
    stat = 3'b110;
    step; step;
    #1; chk("R8 write command before reset", expect_out(3'b110, 2));
    rst = 1'b1;
    #0.5; chk("R9 reset mid write", 8'b0001_1111);
    stat = 3'b111;
    step; chk("R9 held in reset", 8'b0001_1111);
    rst = 1'b0;
    step; chk("R9 idle after release", expect_out(3'b111, 0));
    run_cycle(3'b100, 0, 1'b0, 1'b0, 3'b111);
    step; chk("R1 fetch after reset", expect_out(3'b111, 0));
  endtask

  initial begin
    t_reset;
    t_all_codes;
    t_waits;
    t_halt;
    t_chain;
    t_reset_mid;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule